// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C master from the system clock. Two stages divide the clock. The first is a fixed prescaler that divides by eight and can be bypassed. The second is a modulus divider whose 8-bit setting M gives each half period a length of M+1 prescaled ticks. The programmed period is therefore 2 × (M+1) × P system clocks, where P is 1 when the prescaler is bypassed and 8 when it is active.

The SCL line is driven in open-drain fashion. The block only ever pulls the line low and otherwise releases it. It reads the line back through a synchronizer and starts timing the high phase only once it sees the line actually high. A slow rise time or a slave holding SCL low therefore lengthens the real period beyond the programmed one. One-cycle strobes mark each falling and rising edge for a byte shifter alongside.

A setting written while the clock runs is picked up at the start of the next low phase only. Disabling the block releases the line and returns it to idle at once.

Top module: `i2c_scl_gen`

## Requirements
- R1: With effective modulus M and prescale factor P, each low phase keeps `scl_drive_low` at 1 for exactly (M+1)×P consecutive cycles, so the programmed period is 2×(M+1)×P cycles (6 at the minimum, 4096 at the maximum).
- R2: `pre_bypass` = 1 selects P = 1 (prescaler bypassed); `pre_bypass` = 0 selects P = 8.
- R3: A `div_mod` value of 0 or 1 is treated as 2, so no low phase is shorter than 3×P cycles.
- R4: SCL is read through a two-flop synchronizer. The high phase starts in the cycle after the synchronized line is first seen high and lasts (M+1)×P cycles; the next low phase begins immediately after it.
- R5: After releasing the line, the block waits for as long as the synchronized SCL reads 0 (slow rise or a slave stretching the clock). During that wait it does not drive the line low and emits no rising strobe.
- R6: `div_mod` and `pre_bypass` are captured only when a low phase begins. A change made during a phase does not alter the current low or high phase.
- R7: While `en` is 0, `scl_drive_low`, `scl_fall_stb` and `scl_rise_stb` are all 0 in the same cycle. When `en` returns to 1, a full-length low phase starts on the next clock edge.
- R8: `scl_fall_stb` is 1 exactly in the first cycle of each low phase, which is the cycle in which `scl_drive_low` rises.
- R9: `scl_rise_stb` is 1 for exactly one cycle, in the cycle in which the synchronized SCL is first seen high after a release.
- R10: While `rst_n` is 0, the line is released and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| div_mod | input | DIV_W (8) | Modulus M of the half-period divider |
| pre_bypass | input | 1 | 1 bypasses the divide-by-eight prescaler |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases the line |
| scl_fall_stb | output | 1 | One-cycle strobe at the SCL falling edge |
| scl_rise_stb | output | 1 | One-cycle strobe when SCL is seen high |

## Verification
Three situations are hard to reach from the ports: a settings change that arrives in the middle of a running phase, a disable that lands partway through a long low phase, and a line that stays low after the release. The bench closes the loop by modelling the wired line itself. SCL goes low whenever the block drives it or a stretch flag is set, and goes high a programmable number of cycles after both are clear. Stimulus tasks wait for a falling strobe before they change the modulus, drop `en`, or hold the stretch flag. Those events therefore land at known offsets inside a phase, and the behavioural model checks every cycle that follows.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;
endpackage

// File: rtl/sclk_line_sync.sv
module sclk_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= {STAGES{RST_VAL}};
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];
endmodule

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
   parameter int RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bypass,
   output logic tick
);
   localparam int CW = $clog2(RATIO);
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   logic [CW-1:0] cnt;

   generate
      if ((RATIO & (RATIO - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (clr) cnt <= '0;
            else          cnt <= cnt + 1'b1;
         end
         assign tick = bypass | (&cnt);
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (clr)         cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = bypass | (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
   import sclk_gen_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int MIN_MOD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] mod_in,
   input  logic             byp_in,
   input  logic             scl_hi,
   input  logic             tick,
   output logic             pre_clr,
   output logic             byp_q,
   output logic             drive_low,
   output logic             fall_stb,
   output logic             rise_stb
);
   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_MOD);

   scl_phase_e       state, state_n;
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] mod_q;
   logic [DIV_W-1:0] mod_eff;
   logic             first_q;
   logic             load;
   logic             last_tick;

   assign mod_eff   = (mod_in < MIN_V) ? MIN_V : mod_in;
   assign last_tick = tick && (cnt == mod_q);

   always_comb begin
      state_n = state;
      unique case (state)
         PH_IDLE: state_n = PH_LOW;
         PH_LOW:  if (last_tick) state_n = PH_WAIT;
         PH_WAIT: if (scl_hi)    state_n = PH_HIGH;
         PH_HIGH: if (last_tick) state_n = PH_LOW;
         default: state_n = PH_IDLE;
      endcase
      if (!en) state_n = PH_IDLE;
   end

   assign load    = (state_n == PH_LOW) && (state != PH_LOW);
   assign pre_clr = (state_n != state) || (state == PH_WAIT) || (state == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PH_IDLE;
         cnt     <= '0;
         mod_q   <= MIN_V;
         byp_q   <= 1'b0;
         first_q <= 1'b0;
      end else begin
         state   <= state_n;
         first_q <= load;
         if (state_n != state)
            cnt <= '0;
         else if (tick && (state == PH_LOW || state == PH_HIGH))
            cnt <= cnt + 1'b1;
         if (load) begin
            mod_q <= mod_eff;
            byp_q <= byp_in;
         end
      end
   end

   assign drive_low = en && (state == PH_LOW);
   assign fall_stb  = en && (state == PH_LOW) && first_q;
   assign rise_stb  = en && (state == PH_WAIT) && scl_hi;
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
   parameter int DIV_W       = 8,
   parameter int PRE_RATIO   = 8,
   parameter int MIN_MOD     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_mod,
   input  logic             pre_bypass,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             scl_fall_stb,
   output logic             scl_rise_stb
);
   generate
      if (DIV_W < 2) begin : g_bad_width
         $error("i2c_scl_gen: DIV_W must be at least 2");
      end
      if (PRE_RATIO < 2) begin : g_bad_ratio
         $error("i2c_scl_gen: PRE_RATIO must be at least 2");
      end
      if (MIN_MOD < 0 || MIN_MOD >= (1 << DIV_W)) begin : g_bad_min
         $error("i2c_scl_gen: MIN_MOD must fit in DIV_W bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_scl_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_hi;
   logic tick;
   logic pre_clr;
   logic byp_q;

   sclk_line_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_hi)
   );

   sclk_prescale #(
      .RATIO (PRE_RATIO)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pre_clr),
      .bypass (byp_q),
      .tick   (tick)
   );

   sclk_phase_fsm #(
      .DIV_W   (DIV_W),
      .MIN_MOD (MIN_MOD)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .mod_in    (div_mod),
      .byp_in    (pre_bypass),
      .scl_hi    (scl_hi),
      .tick      (tick),
      .pre_clr   (pre_clr),
      .byp_q     (byp_q),
      .drive_low (scl_drive_low),
      .fall_stb  (scl_fall_stb),
      .rise_stb  (scl_rise_stb)
   );
endmodule

// File: rtl/sclk_gen_checker.sv
module sclk_gen_checker #(
   parameter int MIN_LOW = 3
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic scl_drive_low,
   input logic scl_fall_stb,
   input logic scl_rise_stb
);
   int low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             low_len <= 0;
      else if (scl_drive_low) low_len <= low_len + 1;
      else                    low_len <= 0;
   end

   a_r10_reset_released: assert property (@(posedge clk)
      !rst_n |-> (!scl_drive_low && !scl_fall_stb && !scl_rise_stb));

   a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!scl_drive_low && !scl_fall_stb && !scl_rise_stb));

   a_r8_fall_at_low_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> scl_fall_stb);

   a_r8_fall_only_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall_stb |-> scl_drive_low);

   a_r9_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_stb |=> !scl_rise_stb);

   a_r5_released_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_stb |-> !scl_drive_low);

   a_r3_low_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $fell(scl_drive_low)) |-> (low_len >= MIN_LOW));
endmodule

bind i2c_scl_gen sclk_gen_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en            (en),
   .scl_drive_low (scl_drive_low),
   .scl_fall_stb  (scl_fall_stb),
   .scl_rise_stb  (scl_rise_stb)
);

// File: tb/i2c_scl_gen_test.sv
`timescale 1ns/100ps
module i2c_scl_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] div_mod = 8'd2;
   logic       pre_bypass = 1'b1;
   logic       scl_in = 1'b1;
   logic       scl_drive_low, scl_fall_stb, scl_rise_stb;

   int  n_run = 0;
   int  n_fail = 0;
   bit  stretch = 0;
   int  rise_dly = 0;
   int  hi_cnt = 0;

   // behavioural model state
   int  m_st = 0;      // 0 idle, 1 low, 2 waiting for line, 3 high
   int  m_cnt = 0;
   int  m_len = 0;
   bit  m_first = 0;
   bit  m_s1 = 1, m_s2 = 1;

   always #2 clk = ~clk;

   i2c_scl_gen uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .div_mod       (div_mod),
      .pre_bypass    (pre_bypass),
      .scl_in        (scl_in),
      .scl_drive_low (scl_drive_low),
      .scl_fall_stb  (scl_fall_stb),
      .scl_rise_stb  (scl_rise_stb)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int half_len(input int m, input bit byp);
      int me = (m < 2) ? 2 : m;
      return (me + 1) * (byp ? 1 : 8);
   endfunction

   // model advances on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_len = 0; m_first = 0; m_s1 = 1; m_s2 = 1;
      end else begin
         if (!en) begin
            m_st = 0; m_cnt = 0; m_first = 0;
         end else begin
            case (m_st)
               0: begin m_st = 1; m_cnt = 0; m_len = half_len(div_mod, pre_bypass); m_first = 1; end
               1: begin
                  m_first = 0;
                  m_cnt++;
                  if (m_cnt == m_len) begin m_st = 2; m_cnt = 0; end
               end
               2: if (m_s2) begin m_st = 3; m_cnt = 0; end
               default: begin
                  m_cnt++;
                  if (m_cnt == m_len) begin
                     m_st = 1; m_cnt = 0; m_first = 1;
                     m_len = half_len(div_mod, pre_bypass);
                  end
               end
            endcase
         end
         m_s2 = m_s1;
         m_s1 = scl_in;
      end
   end

   // per-cycle comparison, then the wired line model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1", int'(scl_drive_low), int'(en && m_st == 1), "drive_low vs model");
         check("R8", int'(scl_fall_stb), int'(en && m_st == 1 && m_first), "fall strobe vs model");
         check("R9", int'(scl_rise_stb), int'(en && m_st == 2 && m_s2), "rise strobe vs model");
      end
      if (scl_drive_low || stretch) begin
         hi_cnt = 0;
         scl_in = 1'b0;
      end else begin
         if (hi_cnt < rise_dly) hi_cnt++;
         scl_in = (hi_cnt >= rise_dly);
      end
   end

   task automatic set_in(input bit e, input int m, input bit b);
      @(posedge clk); #1;
      en = e; div_mod = 8'(m); pre_bypass = b;
   endtask

   task automatic wait_fall();
      do @(negedge clk); while (!scl_fall_stb);
   endtask

   task automatic measure_low(output int n);
      wait_fall();
      n = 0;
      while (scl_drive_low) begin n++; @(negedge clk); end
   endtask

   task automatic rise_to_fall(output int n);
      do @(negedge clk); while (!scl_rise_stb);
      n = 0;
      do begin n++; @(negedge clk); end while (!scl_fall_stb);
   endtask

   task automatic fall_to_fall(output int n);
      wait_fall();
      n = 0;
      do begin n++; @(negedge clk); end while (!scl_fall_stb);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int n;
      int rises;
      repeat (3) @(negedge clk);
      check("R10", int'(scl_drive_low), 0, "drive in reset");
      check("R10", int'(scl_fall_stb), 0, "fall strobe in reset");
      check("R10", int'(scl_rise_stb), 0, "rise strobe in reset");
      @(posedge clk); #1 rst_n = 1'b1;

      // minimum setting, prescaler bypassed
      set_in(1, 2, 1);
      measure_low(n);   check("R1", n, 3, "low length M=2 bypass");
      rise_to_fall(n);  check("R4", n, 4, "rise strobe to next fall M=2");
      fall_to_fall(n);  check("R1", n, 9, "period M=2 bypass incl sync");

      // clamp of small modulus values
      set_in(1, 0, 1);
      measure_low(n);   check("R3", n, 3, "low length M=0 clamped");
      set_in(1, 1, 1);
      measure_low(n);   check("R3", n, 3, "low length M=1 clamped");

      // prescaler active
      set_in(1, 3, 0);
      measure_low(n);   check("R2", n, 32, "low length M=3 prescaled");
      set_in(1, 8'h36, 0);
      measure_low(n);   check("R1", n, 440, "low length M=0x36 prescaled");
      rise_to_fall(n);  check("R4", n, 441, "rise strobe to next fall M=0x36");
      fall_to_fall(n);  check("R4", n, 883, "period M=0x36 incl sync");

      // slow rise of the line
      set_in(1, 2, 1);
      measure_low(n);
      rise_dly = 5;
      fall_to_fall(n);  check("R5", n, 13, "period with 5-cycle rise");
      rise_dly = 0;

      // clock stretching by a slave
      wait_fall();
      stretch = 1;
      rises = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (scl_rise_stb) rises++;
         if (i > 4) check("R5", int'(scl_drive_low), 0, "no drive while stretched");
      end
      check("R5", rises, 0, "no rise strobe while stretched");
      stretch = 0;
      rise_to_fall(n);  check("R4", n, 4, "high phase after stretch");

      // settings change in the middle of a low phase
      set_in(1, 3, 1);
      measure_low(n);
      wait_fall();
      n = 1;
      @(posedge clk); #1 div_mod = 8'd5;
      @(negedge clk);
      while (scl_drive_low) begin n++; @(negedge clk); end
      check("R6", n, 4, "current low keeps old modulus");
      measure_low(n);   check("R6", n, 6, "next low uses new modulus");

      // disable partway through a low phase
      set_in(1, 8'h10, 0);
      measure_low(n);
      wait_fall();
      repeat (5) @(negedge clk);
      set_in(0, 8'h10, 0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R7", int'(scl_drive_low | scl_fall_stb | scl_rise_stb), 0, "outputs quiet while disabled");
      end
      set_in(1, 8'h10, 0);
      measure_low(n);   check("R7", n, 136, "fresh low after re-enable");

      // maximum setting
      set_in(1, 8'hFF, 0);
      measure_low(n);
      measure_low(n);   check("R1", n, 2048, "low length M=0xFF prescaled");

      set_in(0, 2, 1);
      repeat (5) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule